// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a free-running time of day for precision time protocol timestamping. The time is a 64-bit count of nanoseconds. Below it sit 32 more bits of fractional nanoseconds. On every clock cycle in which counting is enabled, a programmable fixed-point increment is added to the full 96-bit value. The integer part drives the `tod_ns` output that timestamping logic samples. Software trims the clock frequency by changing the increment. A link-speed change event loads a built-in default increment that suits the new clock rate.

Software reaches the block through a small 32-bit register port. It holds a control word, two time words and two increment words. Reading the low time word captures the whole 64-bit time in a snapshot. The high word read that follows then returns a value coherent with it. A time write and an increment write each stage their low word, and both take effect in one step when the high word is written. Read data is registered and appears on `reg_rdata` in the cycle after the read strobe.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time is 0, counting is disabled (control word at address 0 reads 0) and the active increment is 0x0199999999.
- R2: In each cycle with counting enabled and no time load, the 96-bit accumulator (64 integer plus 32 fraction bits) adds the 64-bit increment (32 integer plus 32 fraction bits), and `tod_ns` shows the integer part.
- R3: While bit 0 of the control word (address 0) is clear, the time does not change.
- R4: A read of address 1 returns the live low time word and captures all 64 bits. A read of address 2 returns the upper half of that capture, not the live upper half.
- R5: A write to address 1 only stages the low time word and leaves the time unchanged. A write to address 2 loads the time with {written word, staged low word}.
- R6: A time load clears the fractional bits. If it falls in a cycle with counting enabled, the load wins and no increment is added in that cycle.
- R7: A write to address 3 only stages the low increment word. A write to address 4 makes {written word, staged low word} the active increment. Reads of addresses 3 and 4 return the low and high words of the active increment.
- R8: A pulse on `link_chg` loads the default for `link_speed`: code 0 gives 0x0199999999, code 1 gives 0x0333333333, code 2 gives 0x2000000000 and code 3 gives 0, so the clock stops. The default replaces any software value and wins over an increment commit in the same cycle.
- R9: `reg_rdata` holds the addressed value in the cycle after a `reg_rd` strobe. Bit 0 of address 0 reads back the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| link_chg | input | 1 | One-cycle pulse that marks a link-speed change |
| link_speed | input | 2 | Link-speed code sampled with `link_chg` |
| tod_ns | output | 64 | Live time of day in nanoseconds |

## Verification
The assertions check on every cycle that the time holds while counting is off, that it never moves backwards while advancing, and that a load leaves exactly the loaded value with zero fraction. They also check that the snapshot and the active increment change only on their own triggers, and that the slowest speed code zeroes the increment. Only the bench's scenarios can show the arithmetic: exact nanosecond values after many fractional additions, the carry of a snapshot read across a low-word wrap, load-over-advance priority, fraction clearing seen through later rounding, and each speed default read back through the register port.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  localparam int unsigned NS_W   = 64;
  localparam int unsigned FRAC_W = 32;
  localparam int unsigned INC_W  = 64;
  localparam int unsigned ACC_W  = NS_W + FRAC_W;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    SPD_FAST = 2'd0,
    SPD_10G  = 2'd1,
    SPD_1G   = 2'd2,
    SPD_SLOW = 2'd3
  } link_speed_e;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_TIME_LO = 3'd1,
    A_TIME_HI = 3'd2,
    A_INC_LO  = 3'd3,
    A_INC_HI  = 3'd4
  } reg_addr_e;

  // Default increment per link speed, 32 fractional bits of nanoseconds.
  function automatic logic [INC_W-1:0] speed_default(input logic [1:0] spd);
    logic [INC_W-1:0] v;
    case (spd)
      SPD_10G:  v = 64'h0000_0003_3333_3333;
      SPD_1G:   v = 64'h0000_0020_0000_0000;
      SPD_SLOW: v = '0;
      default:  v = 64'h0000_0001_9999_9999;
    endcase
    return v;
  endfunction

  // One accumulator step: the increment is zero-extended into the 96-bit value.
  function automatic logic [ACC_W-1:0] acc_advance(input logic [ACC_W-1:0] acc,
                                                   input logic [INC_W-1:0] inc);
    return acc + {{(ACC_W-INC_W){1'b0}}, inc};
  endfunction

  // Loaded value: integer nanoseconds with the fraction cleared.
  function automatic logic [ACC_W-1:0] acc_load(input logic [NS_W-1:0] ns);
    return {ns, {FRAC_W{1'b0}}};
  endfunction

endpackage

// File: rtl/ptp_incr_stage.sv
module ptp_incr_stage
  import ptp_tod_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = INC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [DW-1:0] wdata,
  input  logic          link_chg,
  input  logic [1:0]    link_speed,
  output logic [IW-1:0] inc_active
);

  logic [DW-1:0] lo_stage;
  logic          sw_commit;
  logic          hw_default;

  assign sw_commit  = hi_wr && !link_chg;
  assign hw_default = link_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage   <= '0;
      inc_active <= speed_default(SPD_FAST);
    end else begin
      if (lo_wr) lo_stage <= wdata;
      if (hw_default)     inc_active <= speed_default(link_speed);
      else if (sw_commit) inc_active <= {wdata, lo_stage};
    end
  end

  // R7: the active increment moves only on a commit or a link event
  p_inc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr && !link_chg) |=> $stable(inc_active));

  // R8: the slowest speed code stops the clock
  p_slow_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_chg && link_speed == 2'd3) |=> (inc_active == '0));

  // R8: a link event overrides a same-cycle software commit
  p_link_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_chg && hi_wr) |=> (inc_active == speed_default($past(link_speed))));

endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NW = NS_W,
  parameter int unsigned FW = FRAC_W,
  parameter int unsigned IW = INC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [NW-1:0] load_ns,
  input  logic [IW-1:0] inc,
  output logic [NW-1:0] ns,
  output logic [FW-1:0] frac
);

  localparam int unsigned AW = NW + FW;

  logic [AW-1:0] acc;
  logic          adv_evt;

  assign adv_evt = run && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (load)    acc <= acc_load(load_ns);
    else if (adv_evt) acc <= acc_advance(acc, inc);
  end

  assign ns   = acc[AW-1:FW];
  assign frac = acc[FW-1:0];

  // R3: nothing moves while counting is off and no load is pending
  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(acc));

  // R2: advancing never moves time backwards
  p_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (ns >= $past(ns)));

  // R5: a load leaves exactly the requested nanoseconds
  p_load_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ns == $past(load_ns)));

  // R6: a load clears the fraction, even with counting enabled
  p_frac_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (frac == '0));

endmodule

// File: rtl/ptp_tod_regif.sv
module ptp_tod_regif
  import ptp_tod_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NS_W,
  parameter int unsigned IW = INC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NW-1:0] live_ns,
  input  logic [IW-1:0] inc_active,
  output logic [DW-1:0] rdata,
  output logic          enable,
  output logic          time_load,
  output logic [NW-1:0] time_load_val,
  output logic          inc_lo_wr,
  output logic          inc_hi_wr
);

  logic [DW-1:0] time_lo_stage;
  logic [NW-1:0] snap;
  logic          snap_evt;
  logic [DW-1:0] rd_mux;

  assign snap_evt      = rd && (addr == A_TIME_LO);
  assign time_load     = wr && (addr == A_TIME_HI);
  assign time_load_val = {wdata, time_lo_stage};
  assign inc_lo_wr     = wr && (addr == A_INC_LO);
  assign inc_hi_wr     = wr && (addr == A_INC_HI);

  always_comb begin
    case (addr)
      A_CTRL:    rd_mux = {{(DW-1){1'b0}}, enable};
      A_TIME_LO: rd_mux = live_ns[DW-1:0];
      A_TIME_HI: rd_mux = snap[NW-1:DW];
      A_INC_LO:  rd_mux = inc_active[DW-1:0];
      A_INC_HI:  rd_mux = inc_active[IW-1:DW];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable        <= 1'b0;
      time_lo_stage <= '0;
      snap          <= '0;
      rdata         <= '0;
    end else begin
      if (wr && addr == A_CTRL)    enable        <= wdata[0];
      if (wr && addr == A_TIME_LO) time_lo_stage <= wdata;
      if (snap_evt)                snap          <= live_ns;
      if (rd)                      rdata         <= rd_mux;
    end
  end

  // R4: the snapshot changes only on a low-word time read
  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_evt |=> $stable(snap));

  // R4: the snapshot captures the live time seen by the low-word read
  p_snap_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_evt |=> (snap == $past(live_ns)));

  // R9: read data only changes after a read strobe
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NS_W,
  parameter int unsigned FW = FRAC_W,
  parameter int unsigned IW = INC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          link_chg,
  input  logic [1:0]    link_speed,
  output logic [NW-1:0] tod_ns
);

  logic          enable;
  logic          time_load;
  logic [NW-1:0] time_load_val;
  logic          inc_lo_wr;
  logic          inc_hi_wr;
  logic [IW-1:0] inc_active;
  logic [FW-1:0] frac;

  ptp_tod_regif #(.DW(DW), .AW(AW), .NW(NW), .IW(IW)) u_regif (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd            (reg_rd),
    .wr            (reg_wr),
    .addr          (reg_addr),
    .wdata         (reg_wdata),
    .live_ns       (tod_ns),
    .inc_active    (inc_active),
    .rdata         (reg_rdata),
    .enable        (enable),
    .time_load     (time_load),
    .time_load_val (time_load_val),
    .inc_lo_wr     (inc_lo_wr),
    .inc_hi_wr     (inc_hi_wr)
  );

  ptp_incr_stage #(.DW(DW), .IW(IW)) u_incr (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_wr      (inc_lo_wr),
    .hi_wr      (inc_hi_wr),
    .wdata      (reg_wdata),
    .link_chg   (link_chg),
    .link_speed (link_speed),
    .inc_active (inc_active)
  );

  ptp_tod_accum #(.NW(NW), .FW(FW), .IW(IW)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .load    (time_load),
    .load_ns (time_load_val),
    .inc     (inc_active),
    .ns      (tod_ns),
    .frac    (frac)
  );

  // R6: a load beats a same-cycle advance at the output port
  p_load_over_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (time_load && enable) |=> (tod_ns == $past(time_load_val) && frac == '0));

endmodule

// File: tb/test_ptp_tod_counter.sv
`timescale 1ns/1ps
module test_ptp_tod_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        link_chg = 1'b0;
  logic [1:0]  link_speed = '0;
  logic [63:0] tod_ns;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  ptp_tod_counter i_ptp_tod_counter (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .link_chg(link_chg), .link_speed(link_speed), .tod_ns(tod_ns)
  );

  function automatic logic [63:0] want_default(input logic [1:0] s);
    if (s == 2'd1) return 64'h0333333333;
    if (s == 2'd2) return 64'h2000000000;
    if (s == 2'd3) return 64'h0;
    return 64'h0199999999;
  endfunction

  // time after n additions starting from integer ns with zero fraction
  function automatic logic [63:0] want_time(input logic [63:0] start,
                                            input logic [63:0] inc, input int n);
    logic [127:0] total;
    total = ({64'h0, start} << 32) + (128'(n) * {64'h0, inc});
    return total[95:32];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%h expected=0x%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    t = {hi, lo};
  endtask

  task automatic rd_inc(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'd3, lo);
    rd(3'd4, hi);
    v = {hi, lo};
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(3'd1, t[31:0]);
    wr(3'd2, t[63:32]);
  endtask

  task automatic set_inc(input logic [63:0] v);
    wr(3'd3, v[31:0]);
    wr(3'd4, v[63:32]);
  endtask

  // enable, wait k cycles, disable: k+1 additions
  task automatic run_for(input int k);
    wr(3'd0, 32'd1);
    repeat (k) @(negedge clk);
    wr(3'd0, 32'd0);
  endtask

  task automatic pulse_link(input logic [1:0] s);
    link_speed = s; link_chg = 1'b1;
    @(negedge clk);
    link_chg = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, v, start, inc;
    void'($urandom(32'h1d5e_ed01));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R9: reset state through the port
    rd(3'd0, d);   check("R1 ctrl", {32'h0, d}, 64'h0);
    rd_time(t);    check("R1 time", t, 64'h0);
    rd_inc(v);     check("R1 inc", v, 64'h0199999999);
    check("R1 tod_ns", tod_ns, 64'h0);

    // R9: enable readback
    wr(3'd0, 32'd1);
    rd(3'd0, d);   check("R9 ctrl enable", {32'h0, d}, 64'h1);
    wr(3'd0, 32'd0);

    // R3: counting off keeps time still
    set_time(64'h0000_0010_0000_0000);
    repeat (20) @(negedge clk);
    rd_time(t);    check("R3 hold while off", t, 64'h0000_0010_0000_0000);

    // R5: low word alone does not reload
    wr(3'd1, 32'hDEAD_BEEF);
    rd_time(t);    check("R5 staged low", t, 64'h0000_0010_0000_0000);
    wr(3'd2, 32'h0000_0022);
    rd_time(t);    check("R5 load", t, 64'h0000_0022_DEAD_BEEF);

    // R7: low increment word alone is staged only
    wr(3'd3, 32'h1234_5678);
    rd_inc(v);     check("R7 staged inc", v, 64'h0199999999);
    wr(3'd4, 32'h0000_0002);
    rd_inc(v);     check("R7 commit inc", v, 64'h0000_0002_1234_5678);

    // R8: each speed default, overriding software value
    for (int s = 0; s < 4; s++) begin
      set_inc(64'h0000_0007_7777_7777);
      pulse_link(2'(s));
      rd_inc(v);   check("R8 speed default", v, want_default(2'(s)));
    end

    // R8: code 3 stops the clock even when enabled
    set_time(64'h100);
    run_for(10);
    rd_time(t);    check("R8 stopped clock", t, 64'h100);

    // R8: link event wins over a same-cycle commit
    wr(3'd3, 32'hAAAA_AAAA);
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h5;
    link_speed = 2'd1; link_chg = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; link_chg = 1'b0;
    rd_inc(v);     check("R8 link over commit", v, 64'h0333333333);

    // R2: exact accumulation of 3.2 ns steps
    set_time(64'h0);
    run_for(9);
    rd_time(t);    check("R2 3.2ns x10", t, want_time(64'h0, 64'h0333333333, 10));

    // R4: snapshot across a low-word wrap
    set_inc(64'h1_0000_0000);
    set_time(64'h0000_0005_FFFF_FFF0);
    wr(3'd0, 32'd1);
    repeat (3) @(negedge clk);
    rd(3'd1, d);   check("R4 low read", {32'h0, d}, 64'hFFFF_FFF3);
    repeat (20) @(negedge clk);
    rd(3'd2, d);   check("R4 high from snapshot", {32'h0, d}, 64'h5);
    wr(3'd0, 32'd0);
    rd_time(t);    check("R4 fresh snapshot high", {32'h0, t[63:32]}, 64'h6);

    // R6: load wins over a same-cycle advance
    wr(3'd0, 32'd1);
    set_time(64'h0000_0003_0000_0100);
    wr(3'd0, 32'd0);
    rd_time(t);    check("R6 load over tick", t, 64'h0000_0003_0000_0101);

    // R6: load clears the fraction (0.5 ns steps)
    set_inc(64'h0000_0000_8000_0000);
    set_time(64'h40);
    run_for(0);
    rd_time(t);    check("R6 half step", t, 64'h40);
    set_time(64'h80);
    run_for(0);
    rd_time(t);    check("R6 fraction cleared", t, 64'h80);

    // R2 and R7: random starts, increments and run lengths
    for (int it = 0; it < 12; it++) begin
      int k;
      start = {$urandom & 32'h7FFF_FFFF, $urandom};
      inc   = {32'($urandom_range(0, 40)), $urandom};
      k     = $urandom_range(0, 40);
      set_inc(inc);
      set_time(start);
      run_for(k);
      rd_inc(v);   check("R7 random inc readback", v, inc);
      rd_time(t);  check("R2 random accumulate", t, want_time(start, inc, k + 1));
      check("R2 tod_ns port", tod_ns, want_time(start, inc, k + 1));
    end

    report();
  end

endmodule